// File: doc/BRIEF.md
# Packed SIMD Media Instruction Decoder

This block classifies 32-bit instruction words that belong to a packed-vector media extension whose operands are 64-bit registers. It treats such a register either as eight byte lanes or as four halfword lanes. The block spots the extension's major opcode. It sorts the minor function into an operation class and pulls out the vector register indices. It also decodes the lane format, the element select, the accumulator slice and the align argument. The core's coprocessor-usable flag and two status bits arrive as inputs, and from them the block raises at most one exception flag per word.

The decoded result is held in an output register by default, so it appears one clock after the word is presented. Setting `REG_OUT` to 0 turns the path into pure combinational logic. Executing the operations, the register files and the accumulator datapath are not part of this block.

Top module: `simd_insn_decoder`

## Requirements
- R1: The result appears on the outputs one clock after the inputs are presented, and a synchronous reset clears every output. When `insn_valid` is 0, every output is 0. When the word is valid but bits 31:26 differ from 011110, `out_valid` is 1 and every other output is 0. For a valid word with bits 31:26 equal to 011110, `is_media` is 1 and the indices come straight from the word on every path, exceptions included: `vd_idx` from bits 10:6, `vs_idx` from bits 15:11 and `vt_idx` from bits 20:16.
- R2: For a media word, `cop_usable` = 0 raises `exc_cop_unusable` and no other flag.
- R3: When `cop_usable` is 1 but `st_mx` or `st_fr` is 0, `exc_media_off` is raised and no other flag.
- R4: Some operations take a format selector in bits 25:21. A selector whose low bits 1:0 are 11 raises `exc_reserved`.
- R5: Any minor function not listed below raises `exc_reserved`, and so does any nonzero required-zero field. Required-zero fields are:
  - the destination field of a compare;
  - bits 9:6 of an accumulator op;
  - bits 20:11 of an accumulator read;
  - bits 10:6 of an accumulator write, plus bits 20:16 when the write targets the high slice;
  - bits 25:24 of an immediate align;
  - bits 15:11 of a round op.
- R6: At most one exception flag is high at a time, and the priority order is R2, then R3, then R4/R5. When any flag is high, `op_class` is 0, and `fmt_half`, `elem_sel`, `acc_long`, `acc_slice` and `align_arg` are all 0.
- R7: Three-operand functions map to `op_class` codes as follows:
  - 001011 gives 1 and 001010 gives 2;
  - 001100 gives 3, 001101 gives 4, 001110 gives 5 and 001111 gives 6;
  - 000110 gives 7, 000111 gives 8 and 110000 gives 9;
  - 000010 gives 10, 000011 gives 11, 010000 gives 12 and 010010 gives 13.
- R8: Compares: 000001 gives 15, 000100 gives 16 and 000101 gives 17. Accumulator ops: 110111 gives 18, 110110 gives 19, 110011 gives 20 and 110010 gives 21. For accumulator ops, `acc_long` equals bit 10. For every other op, `acc_long` is 0.
- R9: An accumulator read (111111) gives code 22 and an accumulator write (111110) gives code 23. Bit 21 drives `fmt_half`. Bits 25:22 pick the slice:
  - 1000 gives `acc_slice` 2;
  - 0100 gives `acc_slice` 1, and is allowed for a read only;
  - 0000 gives `acc_slice` 0;
  - any other value is reserved.
- R10: An align function has 0110 in bits 5:2, and bit 1 drives `fmt_half`. When bit 0 is 0, the code is 24 and `align_arg` = {00, bits 23:21}. When bit 0 is 1, the code is 25 and `align_arg` = bits 25:21.
- R11: For format-selector ops, a 0 in bit 21 selects bytes: `fmt_half` is 0 and `elem_sel` = bits 25:22. Bits 22:21 = 01 select halfwords: `fmt_half` is 1 and `elem_sel` = {0, bits 25:23}.
- R12: Halfword-only functions are 010011 (code 14), 000000 (code 26), 100100 (code 27), 100101 (code 28) and 100110 (code 29). They require 01 in bits 22:21 and raise `exc_reserved` otherwise. They output `fmt_half` = 1 and `elem_sel` = {0, bits 25:23}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present |
| insn | input | 32 | Instruction word |
| cop_usable | input | 1 | Coprocessor 1 usable |
| st_mx | input | 1 | Media-enable status bit |
| st_fr | input | 1 | 64-bit register mode status bit |
| out_valid | output | 1 | Decoded result valid |
| is_media | output | 1 | Major opcode matched |
| op_class | output | 5 | Operation class code |
| vd_idx | output | 5 | Destination vector index |
| vs_idx | output | 5 | First source vector index |
| vt_idx | output | 5 | Second source vector index |
| fmt_half | output | 1 | 1 for halfword lanes, 0 for byte lanes |
| elem_sel | output | 4 | Element/vector select from the selector |
| acc_long | output | 1 | Accumulator L-form variant |
| acc_slice | output | 2 | Accumulator slice (2 high, 1 mid, 0 low) |
| align_arg | output | 5 | Align amount or register index |
| exc_cop_unusable | output | 1 | Coprocessor unusable exception |
| exc_media_off | output | 1 | Media extension disabled exception |
| exc_reserved | output | 1 | Reserved instruction exception |

## Verification
The bench targets the places where one field carries two meanings. The selector low bits 11 must trap and must not decode as halfwords. Shift-right-arithmetic must use the halfword-only form, so its byte encoding must trap. The middle slice is legal for a read but not for a write. The ordering of the flags is also exercised. A decoder that checked the format before the status bits would show a reserved flag where the media flag belongs. A decoder that left the class set under an exception would let a trapped word look executable. Random media words with random status bits hit every required-zero field, so a missing zero check shows up as a valid class where the model expects a trap.

// File: rtl/simd_dec_pkg.sv
// Shared constants and types for the packed SIMD decoder.
// Assumes a 32-bit instruction word and 5-bit register indices.
package simd_dec_pkg;
    localparam int INSN_W  = 32;
    localparam int RIDX_W  = 5;
    localparam int FUNC_W  = 6;
    localparam int ESEL_W  = 4;
    localparam int SLICE_W = 2;
    localparam int OPC_W   = 5;
    localparam logic [5:0] MAJOR_OPC = 6'b011110;

    typedef enum logic [OPC_W-1:0] {
        OP_NONE = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_AND = 5'd3,
        OP_XOR  = 5'd4,  OP_OR  = 5'd5,  OP_NOR = 5'd6,  OP_MIN = 5'd7,
        OP_MAX  = 5'd8,  OP_MUL = 5'd9,  OP_PICKF = 5'd10, OP_PICKT = 5'd11,
        OP_SLL  = 5'd12, OP_SRL = 5'd13, OP_SRA = 5'd14, OP_CEQ = 5'd15,
        OP_CLT  = 5'd16, OP_CLE = 5'd17, OP_ACC_ADD = 5'd18, OP_ACC_SUB = 5'd19,
        OP_ACC_MUL = 5'd20, OP_ACC_MULSUB = 5'd21, OP_RDACC = 5'd22,
        OP_WRACC = 5'd23, OP_ALIGN_IMM = 5'd24, OP_ALIGN_REG = 5'd25,
        OP_MSGN = 5'd26, OP_RZS = 5'd27, OP_RNAS = 5'd28, OP_RNES = 5'd29
    } op_class_e;

    // Encoding family: decides how bits 25:21 are read.
    typedef enum logic [2:0] {
        FAM_NONE, FAM_FMTSEL, FAM_HALF, FAM_RDACC, FAM_WRACC, FAM_ALIGN
    } fam_e;

    typedef struct packed {
        logic                valid;
        logic                match;
        op_class_e           op;
        logic [RIDX_W-1:0]   vd;
        logic [RIDX_W-1:0]   vs;
        logic [RIDX_W-1:0]   vt;
        logic                half;
        logic [ESEL_W-1:0]   esel;
        logic                acc_long;
        logic [SLICE_W-1:0]  slice;
        logic [RIDX_W-1:0]   aarg;
        logic                x_cop;
        logic                x_media;
        logic                x_rsv;
    } dec_out_t;
endpackage

// File: rtl/simd_func_classify.sv
// Maps the minor function code to an operation class and encoding family,
// and flags nonzero required-zero fields. Assumes the major opcode is checked elsewhere.
module simd_func_classify
    import simd_dec_pkg::*;
(
    input  logic [FUNC_W-1:0] fn,
    input  logic [3:0]        hi4,    // bits 25:22
    input  logic [14:0]       mid,    // bits 20:6
    output op_class_e         op,
    output fam_e              fam,
    output logic              field_bad
);
    logic [RIDX_W-1:0] f_vt, f_vs, f_vd;
    assign f_vt = mid[14:10];
    assign f_vs = mid[9:5];
    assign f_vd = mid[4:0];

    // Function-code lookup with per-family required-zero checks.
    always_comb begin
        op        = OP_NONE;
        fam       = FAM_NONE;
        field_bad = 1'b0;
        casez (fn)
            6'b001011: begin op = OP_ADD;   fam = FAM_FMTSEL; end
            6'b001010: begin op = OP_SUB;   fam = FAM_FMTSEL; end
            6'b001100: begin op = OP_AND;   fam = FAM_FMTSEL; end
            6'b001101: begin op = OP_XOR;   fam = FAM_FMTSEL; end
            6'b001110: begin op = OP_OR;    fam = FAM_FMTSEL; end
            6'b001111: begin op = OP_NOR;   fam = FAM_FMTSEL; end
            6'b000110: begin op = OP_MIN;   fam = FAM_FMTSEL; end
            6'b000111: begin op = OP_MAX;   fam = FAM_FMTSEL; end
            6'b110000: begin op = OP_MUL;   fam = FAM_FMTSEL; end
            6'b000010: begin op = OP_PICKF; fam = FAM_FMTSEL; end
            6'b000011: begin op = OP_PICKT; fam = FAM_FMTSEL; end
            6'b010000: begin op = OP_SLL;   fam = FAM_FMTSEL; end
            6'b010010: begin op = OP_SRL;   fam = FAM_FMTSEL; end
            6'b000001: begin op = OP_CEQ; fam = FAM_FMTSEL; field_bad = (f_vd != '0); end
            6'b000100: begin op = OP_CLT; fam = FAM_FMTSEL; field_bad = (f_vd != '0); end
            6'b000101: begin op = OP_CLE; fam = FAM_FMTSEL; field_bad = (f_vd != '0); end
            6'b110111: begin op = OP_ACC_ADD;    fam = FAM_FMTSEL; field_bad = (f_vd[3:0] != '0); end
            6'b110110: begin op = OP_ACC_SUB;    fam = FAM_FMTSEL; field_bad = (f_vd[3:0] != '0); end
            6'b110011: begin op = OP_ACC_MUL;    fam = FAM_FMTSEL; field_bad = (f_vd[3:0] != '0); end
            6'b110010: begin op = OP_ACC_MULSUB; fam = FAM_FMTSEL; field_bad = (f_vd[3:0] != '0); end
            6'b111111: begin
                op = OP_RDACC; fam = FAM_RDACC;
                field_bad = (f_vt != '0) || (f_vs != '0) ||
                            !(hi4 == 4'b1000 || hi4 == 4'b0100 || hi4 == 4'b0000);
            end
            6'b111110: begin
                op = OP_WRACC; fam = FAM_WRACC;
                field_bad = (f_vd != '0) || !(hi4 == 4'b1000 || hi4 == 4'b0000) ||
                            (hi4 == 4'b1000 && f_vt != '0);
            end
            6'b0110?0: begin op = OP_ALIGN_IMM; fam = FAM_ALIGN; field_bad = (hi4[3:2] != 2'b00); end
            6'b0110?1: begin op = OP_ALIGN_REG; fam = FAM_ALIGN; end
            6'b000000: begin op = OP_MSGN; fam = FAM_HALF; end
            6'b010011: begin op = OP_SRA;  fam = FAM_HALF; end
            6'b100100: begin op = OP_RZS;  fam = FAM_HALF; field_bad = (f_vs != '0); end
            6'b100101: begin op = OP_RNAS; fam = FAM_HALF; field_bad = (f_vs != '0); end
            6'b100110: begin op = OP_RNES; fam = FAM_HALF; field_bad = (f_vs != '0); end
            default:   begin op = OP_NONE; fam = FAM_NONE; end
        endcase
    end
endmodule

// File: rtl/simd_fmt_select.sv
// Interprets bits 25:21 according to the encoding family: lane format,
// element select, accumulator slice and align argument. Flags a bad selector.
module simd_fmt_select
    import simd_dec_pkg::*;
(
    input  op_class_e           op,
    input  fam_e                fam,
    input  logic [4:0]          sel,    // bits 25:21
    input  logic                fbit,   // bit 1, align format
    input  logic                lbit,   // bit 10, accumulator L form
    output logic                half,
    output logic [ESEL_W-1:0]   esel,
    output logic                acc_long,
    output logic [SLICE_W-1:0]  slice,
    output logic [RIDX_W-1:0]   aarg,
    output logic                fmt_bad
);
    // Per-family interpretation of the selector field.
    always_comb begin
        half     = 1'b0;
        esel     = '0;
        acc_long = 1'b0;
        slice    = '0;
        aarg     = '0;
        fmt_bad  = 1'b0;
        case (fam)
            FAM_FMTSEL: begin
                if (!sel[0]) begin
                    esel = sel[4:1];
                end else if (!sel[1]) begin
                    half = 1'b1;
                    esel = {1'b0, sel[4:2]};
                end else begin
                    fmt_bad = 1'b1;
                end
                acc_long = lbit && (op inside {OP_ACC_ADD, OP_ACC_SUB, OP_ACC_MUL, OP_ACC_MULSUB});
            end
            FAM_HALF: begin
                if (sel[1:0] == 2'b01) begin
                    half = 1'b1;
                    esel = {1'b0, sel[4:2]};
                end else begin
                    fmt_bad = 1'b1;
                end
            end
            FAM_RDACC, FAM_WRACC: begin
                half = sel[0];
                case (sel[4:1])
                    4'b1000: slice = 2'd2;
                    4'b0100: slice = 2'd1;
                    default: slice = 2'd0;
                endcase
            end
            FAM_ALIGN: begin
                half = fbit;
                aarg = (op == OP_ALIGN_REG) ? sel : {2'b00, sel[2:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_exc_chain.sv
// Ordered exception chain: coprocessor unusable, then media disabled, then
// reserved. Assumes rsv_cond already merges all reserved-encoding causes.
module simd_exc_chain (
    input  logic match,
    input  logic cop_ok,
    input  logic mx,
    input  logic fr,
    input  logic rsv_cond,
    output logic x_cop,
    output logic x_media,
    output logic x_rsv
);
    // Each stage fires only if every earlier stage passed.
    always_comb begin
        x_cop   = match && !cop_ok;
        x_media = match && cop_ok && !(mx && fr);
        x_rsv   = match && cop_ok && mx && fr && rsv_cond;
    end
endmodule

// File: rtl/simd_insn_decoder.sv
// Top of the packed SIMD instruction decoder. Matches the major opcode,
// combines classification, selector decode and the exception chain, and
// optionally registers the result (REG_OUT=1, one cycle latency).
module simd_insn_decoder
    import simd_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [INSN_W-1:0]   insn,
    input  logic                cop_usable,
    input  logic                st_mx,
    input  logic                st_fr,
    output logic                out_valid,
    output logic                is_media,
    output logic [OPC_W-1:0]    op_class,
    output logic [RIDX_W-1:0]   vd_idx,
    output logic [RIDX_W-1:0]   vs_idx,
    output logic [RIDX_W-1:0]   vt_idx,
    output logic                fmt_half,
    output logic [ESEL_W-1:0]   elem_sel,
    output logic                acc_long,
    output logic [SLICE_W-1:0]  acc_slice,
    output logic [RIDX_W-1:0]   align_arg,
    output logic                exc_cop_unusable,
    output logic                exc_media_off,
    output logic                exc_reserved
);
    logic               match;
    op_class_e          cls_op;
    fam_e               cls_fam;
    logic               field_bad;
    logic               s_half, s_long, s_bad;
    logic [ESEL_W-1:0]  s_esel;
    logic [SLICE_W-1:0] s_slice;
    logic [RIDX_W-1:0]  s_aarg;
    logic               x_cop, x_media, x_rsv, ok;
    dec_out_t           d, q;

    assign match = insn_valid && (insn[31:26] == MAJOR_OPC);

    simd_func_classify u_cls (
        .fn        (insn[5:0]),
        .hi4       (insn[25:22]),
        .mid       (insn[20:6]),
        .op        (cls_op),
        .fam       (cls_fam),
        .field_bad (field_bad)
    );

    simd_fmt_select u_sel (
        .op       (cls_op),
        .fam      (cls_fam),
        .sel      (insn[25:21]),
        .fbit     (insn[1]),
        .lbit     (insn[10]),
        .half     (s_half),
        .esel     (s_esel),
        .acc_long (s_long),
        .slice    (s_slice),
        .aarg     (s_aarg),
        .fmt_bad  (s_bad)
    );

    simd_exc_chain u_exc (
        .match    (match),
        .cop_ok   (cop_usable),
        .mx       (st_mx),
        .fr       (st_fr),
        .rsv_cond (field_bad || s_bad || (cls_op == OP_NONE)),
        .x_cop    (x_cop),
        .x_media  (x_media),
        .x_rsv    (x_rsv)
    );

    assign ok = match && !(x_cop || x_media || x_rsv);

    // Assemble the decoded record; attributes are cleared under an exception.
    always_comb begin
        d          = '0;
        d.valid    = insn_valid;
        d.match    = match;
        d.op       = ok ? cls_op : OP_NONE;
        d.vd       = match ? insn[10:6]  : '0;
        d.vs       = match ? insn[15:11] : '0;
        d.vt       = match ? insn[20:16] : '0;
        d.half     = ok && s_half;
        d.esel     = ok ? s_esel  : '0;
        d.acc_long = ok && s_long;
        d.slice    = ok ? s_slice : '0;
        d.aarg     = ok ? s_aarg  : '0;
        d.x_cop    = x_cop;
        d.x_media  = x_media;
        d.x_rsv    = x_rsv;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({q.x_cop, q.x_media, q.x_rsv})); // R6
            AST_EXC_CLEARS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
                (q.x_cop || q.x_media || q.x_rsv) |-> (q.op == OP_NONE && q.slice == '0)); // R6
            AST_COP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_valid && insn[31:26] == MAJOR_OPC && !cop_usable) |=> q.x_cop); // R2
            AST_MEDIA_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_valid && insn[31:26] == MAJOR_OPC && cop_usable && !(st_mx && st_fr))
                |=> (q.x_media && !q.x_rsv)); // R3
            AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_valid && insn[31:26] != MAJOR_OPC)
                |=> (q.valid && !q.match && q.op == OP_NONE && !q.x_rsv)); // R1
            AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !insn_valid |=> (!q.valid && !q.match)); // R1
        end else begin : g_comb
            assign q = d;
        end
    endgenerate

    assign out_valid        = q.valid;
    assign is_media         = q.match;
    assign op_class         = q.op;
    assign vd_idx           = q.vd;
    assign vs_idx           = q.vs;
    assign vt_idx           = q.vt;
    assign fmt_half         = q.half;
    assign elem_sel         = q.esel;
    assign acc_long         = q.acc_long;
    assign acc_slice        = q.slice;
    assign align_arg        = q.aarg;
    assign exc_cop_unusable = q.x_cop;
    assign exc_media_off    = q.x_media;
    assign exc_reserved     = q.x_rsv;
endmodule

// File: tb/simd_insn_decoder_test.sv
`timescale 1ns/1ps
module simd_insn_decoder_test;
    typedef struct packed {
        logic       valid;
        logic       match;
        logic [4:0] op;
        logic [4:0] vd;
        logic [4:0] vs;
        logic [4:0] vt;
        logic       half;
        logic [3:0] esel;
        logic       lng;
        logic [1:0] slice;
        logic [4:0] aarg;
        logic       xc;
        logic       xm;
        logic       xr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        cop_usable = 1'b0, st_mx = 1'b0, st_fr = 1'b0;
    logic        out_valid, is_media, fmt_half, acc_long;
    logic        exc_cop_unusable, exc_media_off, exc_reserved;
    logic [4:0]  op_class, vd_idx, vs_idx, vt_idx, align_arg;
    logic [3:0]  elem_sel;
    logic [1:0]  acc_slice;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    exp_t  prev_exp = '0;
    string prev_tag = "R1 reset state";

    always #2 clk = ~clk;

    simd_insn_decoder uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .cop_usable(cop_usable), .st_mx(st_mx), .st_fr(st_fr),
        .out_valid(out_valid), .is_media(is_media), .op_class(op_class),
        .vd_idx(vd_idx), .vs_idx(vs_idx), .vt_idx(vt_idx), .fmt_half(fmt_half),
        .elem_sel(elem_sel), .acc_long(acc_long), .acc_slice(acc_slice),
        .align_arg(align_arg), .exc_cop_unusable(exc_cop_unusable),
        .exc_media_off(exc_media_off), .exc_reserved(exc_reserved)
    );

    // Behavioural model written from the requirement list.
    function automatic exp_t model(input logic [31:0] w, input logic v, cu, mx, fr);
        exp_t e;
        int   cls;
        int   fam;   // 1 selector, 2 halfword-only, 3 read acc, 4 write acc, 5 align
        bit   bad;
        e = '0;
        if (!v) return e;
        e.valid = 1'b1;
        if (w[31:26] != 6'b011110) return e;
        e.match = 1'b1;
        e.vd = w[10:6]; e.vs = w[15:11]; e.vt = w[20:16];
        if (!cu) begin e.xc = 1'b1; return e; end
        if (!(mx && fr)) begin e.xm = 1'b1; return e; end
        cls = 0; fam = 0; bad = 1'b0;
        if (w[5:2] == 4'b0110) begin
            fam = 5;
            cls = w[0] ? 25 : 24;
            if (!w[0] && w[25:24] != 2'b00) bad = 1'b1;
        end else begin
            case (w[5:0])
                6'b001011: cls = 1;  6'b001010: cls = 2;  6'b001100: cls = 3;
                6'b001101: cls = 4;  6'b001110: cls = 5;  6'b001111: cls = 6;
                6'b000110: cls = 7;  6'b000111: cls = 8;  6'b110000: cls = 9;
                6'b000010: cls = 10; 6'b000011: cls = 11; 6'b010000: cls = 12;
                6'b010010: cls = 13; 6'b000001: cls = 15; 6'b000100: cls = 16;
                6'b000101: cls = 17; 6'b110111: cls = 18; 6'b110110: cls = 19;
                6'b110011: cls = 20; 6'b110010: cls = 21; 6'b111111: cls = 22;
                6'b111110: cls = 23; 6'b010011: cls = 14; 6'b000000: cls = 26;
                6'b100100: cls = 27; 6'b100101: cls = 28; 6'b100110: cls = 29;
                default:   cls = 0;
            endcase
            if (cls >= 1 && cls <= 13) fam = 1;
            if (cls >= 15 && cls <= 21) fam = 1;
            if (cls == 14 || cls >= 26) fam = 2;
            if (cls == 22) fam = 3;
            if (cls == 23) fam = 4;
        end
        if (cls >= 15 && cls <= 17 && w[10:6] != 0) bad = 1'b1;
        if (cls >= 18 && cls <= 21 && w[9:6] != 0) bad = 1'b1;
        if (cls >= 27 && w[15:11] != 0) bad = 1'b1;
        if (fam == 1 && w[22:21] == 2'b11) bad = 1'b1;
        if (fam == 2 && w[22:21] != 2'b01) bad = 1'b1;
        if (fam == 3 && (w[20:11] != 0 || !(w[25:22] == 4'b1000 || w[25:22] == 4'b0100 || w[25:22] == 4'b0000)))
            bad = 1'b1;
        if (fam == 4 && (w[10:6] != 0 || !(w[25:22] == 4'b1000 || w[25:22] == 4'b0000) ||
                         (w[25:22] == 4'b1000 && w[20:16] != 0)))
            bad = 1'b1;
        if (cls == 0 || bad) begin e.xr = 1'b1; return e; end
        e.op = cls[4:0];
        case (fam)
            1: begin
                if (w[21] == 1'b0) e.esel = w[25:22];
                else begin e.half = 1'b1; e.esel = {1'b0, w[25:23]}; end
                if (cls >= 18 && cls <= 21) e.lng = w[10];
            end
            2: begin e.half = 1'b1; e.esel = {1'b0, w[25:23]}; end
            3, 4: begin
                e.half = w[21];
                e.slice = (w[25:22] == 4'b1000) ? 2'd2 : (w[25:22] == 4'b0100) ? 2'd1 : 2'd0;
            end
            5: begin
                e.half = w[1];
                e.aarg = w[0] ? w[25:21] : {2'b00, w[23:21]};
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] sel, vt, vs, vd, input logic [5:0] fn);
        return {6'b011110, sel, vt, vs, vd, fn};
    endfunction

    task automatic compare(input exp_t e, input string tag);
        exp_t got;
        got = {out_valid, is_media, op_class, vd_idx, vs_idx, vt_idx, fmt_half,
               elem_sel, acc_long, acc_slice, align_arg, exc_cop_unusable,
               exc_media_off, exc_reserved};
        n_cmp++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
    endtask

    // One clock: check the result of the previous word, then drive the next.
    task automatic step(input logic [31:0] w, input logic v, cu, mx, fr, input string tag);
        @(negedge clk);
        compare(prev_exp, prev_tag);
        insn = w; insn_valid = v; cop_usable = cu; st_mx = mx; st_fr = fr;
        prev_exp = model(w, v, cu, mx, fr);
        prev_tag = tag;
    endtask

    task automatic go(input logic [31:0] w, input string tag);
        step(w, 1'b1, 1'b1, 1'b1, 1'b1, tag);
    endtask

    initial begin
        logic [5:0] three_op [10];
        logic [5:0] pool [16];
        three_op = '{6'b001100, 6'b001101, 6'b001110, 6'b001111, 6'b000110,
                     6'b000111, 6'b110000, 6'b000010, 6'b000011, 6'b010000};
        pool = '{6'b001011, 6'b000001, 6'b110111, 6'b110010, 6'b111111, 6'b111110,
                 6'b011000, 6'b011011, 6'b000000, 6'b010011, 6'b100100, 6'b100110,
                 6'b011111, 6'b100000, 6'b000101, 6'b010010};
        repeat (3) @(negedge clk);
        compare('0, "R1 outputs held at zero in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R7 / R11 format selector forms
        go(mk(5'b10110, 5'd3, 5'd4, 5'd5, 6'b001011), "R7 R11 add bytes");
        go(mk(5'b01101, 5'd7, 5'd8, 5'd9, 6'b001010), "R11 sub halfwords");
        go(mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b001100), "R4 selector 11 reserved");
        step(mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b001100), 1'b1, 1'b0, 1'b0, 1'b0, "R2 cop unusable wins");
        step(mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b001100), 1'b1, 1'b1, 1'b0, 1'b1, "R3 MX clear wins over reserved");
        step(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 1'b1, 1'b1, 1'b1, 1'b0, "R3 FR clear");
        for (int i = 0; i < 10; i++)
            go(mk(5'(2 * i), 5'(i), 5'(i + 1), 5'(i + 2), three_op[i]), "R7 three-operand codes");
        // R8 compares and accumulator ops
        go(mk(5'b00101, 5'd2, 5'd3, 5'd0, 6'b000001), "R8 compare equal");
        go(mk(5'b00101, 5'd2, 5'd3, 5'd1, 6'b000001), "R5 compare with destination");
        go(mk(5'b00000, 5'd2, 5'd3, 5'd0, 6'b000100), "R8 compare less");
        go(mk(5'b00000, 5'd2, 5'd3, 5'd0, 6'b000101), "R8 compare less-equal");
        go(mk(5'b00001, 5'd2, 5'd3, 5'b10000, 6'b110111), "R8 acc add long");
        go(mk(5'b00001, 5'd2, 5'd3, 5'b00000, 6'b110110), "R8 acc sub plain");
        go(mk(5'b00000, 5'd2, 5'd3, 5'b00001, 6'b110011), "R5 acc mul bits 9:6 nonzero");
        go(mk(5'b00000, 5'd2, 5'd3, 5'b10000, 6'b110010), "R8 acc mulsub long");
        // R9 accumulator read/write
        go(mk(5'b10001, 5'd0, 5'd0, 5'd4, 6'b111111), "R9 read high halfwords");
        go(mk(5'b01000, 5'd0, 5'd0, 5'd4, 6'b111111), "R9 read middle");
        go(mk(5'b00000, 5'd0, 5'd0, 5'd4, 6'b111111), "R9 read low");
        go(mk(5'b11000, 5'd0, 5'd0, 5'd4, 6'b111111), "R9 read bad slice");
        go(mk(5'b00000, 5'd0, 5'd7, 5'd4, 6'b111111), "R5 read with source field");
        go(mk(5'b10000, 5'd0, 5'd6, 5'd0, 6'b111110), "R9 write high");
        go(mk(5'b00001, 5'd3, 5'd6, 5'd0, 6'b111110), "R9 write low halfwords");
        go(mk(5'b01000, 5'd0, 5'd6, 5'd0, 6'b111110), "R9 write middle reserved");
        go(mk(5'b10000, 5'd3, 5'd6, 5'd0, 6'b111110), "R5 write high with vt");
        go(mk(5'b00000, 5'd3, 5'd6, 5'd2, 6'b111110), "R5 write with destination");
        // R10 align
        go(mk(5'b00101, 5'd1, 5'd2, 5'd3, 6'b011010), "R10 align immediate 5 halfwords");
        go(mk(5'b01101, 5'd1, 5'd2, 5'd3, 6'b011000), "R10 align immediate bits 25:24 set");
        go(mk(5'b10011, 5'd1, 5'd2, 5'd3, 6'b011001), "R10 align register form");
        // R12 halfword-only
        go(mk(5'b10101, 5'd1, 5'd2, 5'd3, 6'b000000), "R12 multiply-sign");
        go(mk(5'b10100, 5'd1, 5'd2, 5'd3, 6'b000000), "R12 multiply-sign byte form");
        go(mk(5'b01001, 5'd1, 5'd2, 5'd3, 6'b010011), "R12 arithmetic shift");
        go(mk(5'b01000, 5'd1, 5'd2, 5'd3, 6'b010011), "R12 arithmetic shift byte form");
        go(mk(5'b11101, 5'd4, 5'd0, 5'd3, 6'b100100), "R12 round zero");
        go(mk(5'b00001, 5'd4, 5'd0, 5'd3, 6'b100101), "R12 round away");
        go(mk(5'b00001, 5'd4, 5'd0, 5'd3, 6'b100110), "R12 round even");
        go(mk(5'b00001, 5'd4, 5'd1, 5'd3, 6'b100110), "R5 round with source field");
        // R5 unknown, R1 foreign and idle
        go(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b011111), "R5 unlisted shuffle code");
        go(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b100000), "R5 unlisted code");
        go({6'b010001, 26'h2AB_CDEF}, "R1 foreign major opcode");
        step(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 1'b0, 1'b1, 1'b1, 1'b1, "R1 not valid");
        // R6 random media words with random status
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            logic [3:0]  r;
            w = $urandom;
            r = 4'($urandom);
            if (r[2:0] != 3'b000) w[31:26] = 6'b011110;
            if (r[3]) w[5:0] = pool[$urandom % 16];
            if (r[1:0] == 2'b00) w[25:6] = w[25:6] & 20'h0F00F;
            step(w, 1'b1, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
                 "R6 random word");
        end
        step('0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 idle tail");
        @(negedge clk);
        compare(prev_exp, prev_tag);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule